// File: doc/BRIEF.md
# Integer ALU with Zero/Negative/Overflow/Carry Flags

This block is the combinational arithmetic and logic stage of a small 32-bit RISC core. It receives a first operand, a register operand, and a 16-bit constant. It also receives a 3-bit operation selector, the current condition flags, a flag-update enable and a shift-kind select. From these it returns the result word and the next values of the Zero, Negative, Overflow and Carry flags. The current Carry flag serves as the carry input for the add-with-carry and subtract-with-borrow operations.

When the constant operand is selected, the block builds the second operand itself. For non-shift operations, the constant is placed in either the upper or the lower half of the word. The unused half is filled with zeros, or with ones for AND. For a shift, the constant is sign-extended, and its low bits give a signed amount: positive values shift left and negative values shift right. The block stores no state. The caller decides whether to latch the returned flags. When updates are disabled, the block returns the incoming flags unchanged.

Top module: `alu_flags_core`

## Requirements
- R1: The operation selector `op_i` is decoded as 000 add, 001 add with carry, 010 subtract, 011 subtract with borrow, 100 AND, 101 OR, 110 XOR, 111 shift. The result is available in the same cycle.
- R2: With `use_imm_i`=1 and a non-shift, non-AND operation, the 16-bit constant forms the upper half of the second operand when `imm_high_i`=1, or the lower half when it is 0. The other half is 0x0000.
- R3: With `use_imm_i`=1 and AND, the half not taken by the constant is 0xFFFF.
- R4: Subtract computes a + ~b + 1. Add with carry computes a + b + `c_i`. Subtract with borrow computes a + ~b + `c_i`.
- R5: When flags update, Z is 1 exactly when the result is zero, and N equals result bit 31.
- R6: For the four arithmetic operations, V is 1 when the two addend sign bits match and the result sign differs from them. For all other operations, V is 0.
- R7: For arithmetic operations, C is the carry out of bit 31. For left shifts, C is the last bit shifted out. For right shifts, zero-amount shifts and logic operations, C is 0.
- R8: With `flag_en_i`=0, the outputs `z_o`, `n_o`, `v_o` and `c_o` equal `z_i`, `n_i`, `v_i` and `c_i`, whatever the operation.
- R9: For a shift, bits [5:0] of the second operand are read as a signed amount in the range -31 to +31. A positive amount shifts left. A negative amount shifts right by its magnitude, logically when `shift_arith_i`=0 and arithmetically when it is 1. A constant used as a shift amount is sign-extended.
- R10: With `use_imm_i`=0, the second operand is `b_reg_i` unchanged, and `imm_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation selector |
| a_i | input | 32 | First operand |
| b_reg_i | input | 32 | Register second operand |
| imm_i | input | 16 | Constant for the immediate form |
| use_imm_i | input | 1 | Select the constant as second operand |
| imm_high_i | input | 1 | Place the constant in the upper half |
| shift_arith_i | input | 1 | Arithmetic (1) or logical (0) right shift |
| flag_en_i | input | 1 | Allow the flags to change |
| z_i | input | 1 | Current Zero flag |
| n_i | input | 1 | Current Negative flag |
| v_i | input | 1 | Current Overflow flag |
| c_i | input | 1 | Current Carry flag, also the carry input |
| result_o | output | 32 | Operation result |
| z_o | output | 1 | Next Zero flag |
| n_o | output | 1 | Next Negative flag |
| v_o | output | 1 | Next Overflow flag |
| c_o | output | 1 | Next Carry flag |

## Verification
The bench builds the block with its default 32-bit word and 16-bit constant. At this width the signed boundary operands 0x7FFFFFFF and 0x80000000 can drive both the overflow and the carry-out flags. Shifts by every amount from +31 to -31 can be reached, including the full-width ±31 cases where the carry takes the last bit shifted out. A sweep crosses all eight operations with the boundary operands and both carry-in values, and compares each outcome against an independent signed and unsigned model.

// File: rtl/alu_pkg.sv
// Package: shared operation encoding for the ALU block.
// Assumes: a 3-bit selector, where bit 2 clear marks the arithmetic group.
package alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD   = 3'b000,
        OP_ADDC  = 3'b001,
        OP_SUB   = 3'b010,
        OP_SUBB  = 3'b011,
        OP_AND   = 3'b100,
        OP_OR    = 3'b101,
        OP_XOR   = 3'b110,
        OP_SHIFT = 3'b111
    } alu_op_e;

    // True for the four add/subtract variants.
    function automatic logic is_arith(input alu_op_e op);
        return (op[2] == 1'b0);
    endfunction

endpackage

// File: rtl/alu_operand_sel.sv
// Module: forms the second operand from the register value or the constant.
// Assumes: W is twice IMM_W. A shift sign-extends the constant.
// AND fills the unused half with ones; other operations fill it with zeros.
module alu_operand_sel
    import alu_pkg::*;
#(
    parameter int W     = 32,
    parameter int IMM_W = 16
) (
    input  alu_op_e          op_i,
    input  logic [W-1:0]     b_reg_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic             use_imm_i,
    input  logic             imm_high_i,
    output logic [W-1:0]     b_o
);
    localparam int FILL_W = W - IMM_W;

    logic [FILL_W-1:0] fill;
    logic [W-1:0]      placed;
    logic [W-1:0]      extended;

    // Pick the filler for the half the constant does not occupy.
    always_comb begin
        fill = (op_i == OP_AND) ? {FILL_W{1'b1}} : {FILL_W{1'b0}};
    end

    // Place the constant high or low, and build its sign extension.
    always_comb begin
        placed   = imm_high_i ? {imm_i, fill} : {fill, imm_i};
        extended = {{FILL_W{imm_i[IMM_W-1]}}, imm_i};
    end

    // Choose the final second operand.
    always_comb begin
        if (!use_imm_i)
            b_o = b_reg_i;
        else if (op_i == OP_SHIFT)
            b_o = extended;
        else
            b_o = placed;
    end

endmodule

// File: rtl/alu_adder.sv
// Module: add/subtract datapath with carry out and signed overflow.
// Assumes: op_i is one of the arithmetic codes. Other codes still produce
// values, but the caller ignores them.
module alu_adder
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         carry_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);
    logic [W-1:0] addend;
    logic         cin;
    logic [W:0]   wide;

    // Invert the addend for the subtract forms and choose the carry-in.
    always_comb begin
        addend = op_i[1] ? ~b_i : b_i;
        unique case (op_i)
            OP_ADD:  cin = 1'b0;
            OP_SUB:  cin = 1'b1;
            default: cin = carry_i;
        endcase
    end

    // Wide addition: the extra top bit is the carry out.
    always_comb begin
        wide   = {1'b0, a_i} + {1'b0, addend} + {{W{1'b0}}, cin};
        sum_o  = wide[W-1:0];
        cout_o = wide[W];
        ovf_o  = (a_i[W-1] == addend[W-1]) && (wide[W-1] != a_i[W-1]);
    end

endmodule

// File: rtl/alu_shifter.sv
// Module: bidirectional shifter driven by one signed amount.
// Assumes: the amount lies within +/-(W-1). Positive shifts left and
// negative shifts right. Carry is the last bit out on a left shift, else 0.
module alu_shifter #(
    parameter int W    = 32,
    parameter int SH_W = $clog2(W) + 1
) (
    input  logic [W-1:0]    a_i,
    input  logic [SH_W-1:0] amt_i,
    input  logic            arith_i,
    output logic [W-1:0]    res_o,
    output logic            cout_o
);
    logic            go_right;
    logic [SH_W-1:0] mag;
    logic [W:0]      left_wide;
    logic [W-1:0]    right_res;

    // Split the signed amount into a direction and a magnitude.
    always_comb begin
        go_right = amt_i[SH_W-1];
        mag      = go_right ? (~amt_i + 1'b1) : amt_i;
    end

    // Left path keeps one extra bit to capture the last bit shifted out.
    always_comb begin
        left_wide = {1'b0, a_i} << mag;
    end

    // Right path: logical or sign-filling.
    always_comb begin
        if (arith_i)
            right_res = $signed(a_i) >>> mag;
        else
            right_res = a_i >> mag;
    end

    // Merge both paths.
    always_comb begin
        res_o  = go_right ? right_res : left_wide[W-1:0];
        cout_o = go_right ? 1'b0 : left_wide[W];
    end

endmodule

// File: rtl/alu_flag_unit.sv
// Module: computes the next Z/N/V/C values, or passes the current ones through.
// Assumes: the datapath side-results come from the adder and the shifter.
module alu_flag_unit
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] result_i,
    input  logic         add_cout_i,
    input  logic         add_ovf_i,
    input  logic         sh_cout_i,
    input  logic         en_i,
    input  logic         z_i,
    input  logic         n_i,
    input  logic         v_i,
    input  logic         c_i,
    output logic         z_o,
    output logic         n_o,
    output logic         v_o,
    output logic         c_o
);
    logic z_new, n_new, v_new, c_new;

    // Derive fresh flag values by operation class.
    always_comb begin
        z_new = (result_i == '0);
        n_new = result_i[W-1];
        v_new = is_arith(op_i) ? add_ovf_i : 1'b0;
        if (is_arith(op_i))
            c_new = add_cout_i;
        else if (op_i == OP_SHIFT)
            c_new = sh_cout_i;
        else
            c_new = 1'b0;
    end

    // Apply the update enable.
    always_comb begin
        if (en_i) begin
            z_o = z_new; n_o = n_new; v_o = v_new; c_o = c_new;
        end else begin
            z_o = z_i;   n_o = n_i;   v_o = v_i;   c_o = c_i;
        end
    end

endmodule

// File: rtl/alu_flags_core.sv
// Module: top of the combinational ALU. It forms the operand, runs the
// adder, logic and shifter paths, selects the result and produces the flags.
// Assumes: the caller owns flag storage; c_i is both a flag and the carry-in.
module alu_flags_core
    import alu_pkg::*;
#(
    parameter int W     = 32,
    parameter int IMM_W = 16
) (
    input  logic [2:0]       op_i,
    input  logic [W-1:0]     a_i,
    input  logic [W-1:0]     b_reg_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic             use_imm_i,
    input  logic             imm_high_i,
    input  logic             shift_arith_i,
    input  logic             flag_en_i,
    input  logic             z_i,
    input  logic             n_i,
    input  logic             v_i,
    input  logic             c_i,
    output logic [W-1:0]     result_o,
    output logic             z_o,
    output logic             n_o,
    output logic             v_o,
    output logic             c_o
);
    localparam int SH_W = $clog2(W) + 1;

    alu_op_e      op;
    logic [W-1:0] b_eff;
    logic [W-1:0] sum;
    logic         add_cout, add_ovf;
    logic [W-1:0] sh_res;
    logic         sh_cout;
    logic [W-1:0] logic_res;

    // Give the raw selector its enumerated type.
    always_comb op = alu_op_e'(op_i);

    alu_operand_sel #(.W(W), .IMM_W(IMM_W)) u_opsel (
        .op_i(op), .b_reg_i(b_reg_i), .imm_i(imm_i),
        .use_imm_i(use_imm_i), .imm_high_i(imm_high_i), .b_o(b_eff)
    );

    alu_adder #(.W(W)) u_add (
        .op_i(op), .a_i(a_i), .b_i(b_eff), .carry_i(c_i),
        .sum_o(sum), .cout_o(add_cout), .ovf_o(add_ovf)
    );

    alu_shifter #(.W(W), .SH_W(SH_W)) u_shift (
        .a_i(a_i), .amt_i(b_eff[SH_W-1:0]), .arith_i(shift_arith_i),
        .res_o(sh_res), .cout_o(sh_cout)
    );

    // Bitwise logic group.
    always_comb begin
        unique case (op)
            OP_AND:  logic_res = a_i & b_eff;
            OP_OR:   logic_res = a_i | b_eff;
            default: logic_res = a_i ^ b_eff;
        endcase
    end

    // Final result select by operation class.
    always_comb begin
        if (is_arith(op))
            result_o = sum;
        else if (op == OP_SHIFT)
            result_o = sh_res;
        else
            result_o = logic_res;
    end

    alu_flag_unit #(.W(W)) u_flags (
        .op_i(op), .result_i(result_o), .add_cout_i(add_cout),
        .add_ovf_i(add_ovf), .sh_cout_i(sh_cout), .en_i(flag_en_i),
        .z_i(z_i), .n_i(n_i), .v_i(v_i), .c_i(c_i),
        .z_o(z_o), .n_o(n_o), .v_o(v_o), .c_o(c_o)
    );

    // Checks across the operand former, the datapath and the flag unit.
    always_comb begin
        p_and_fill_r3: assert (!(use_imm_i && op == OP_AND && !imm_high_i)
                               || (b_eff[W-1:IMM_W] == '1))
            else $error("AND constant fill is not all ones");
        p_hold_flags_r8: assert (flag_en_i ||
                                 ({z_o, n_o, v_o, c_o} == {z_i, n_i, v_i, c_i}))
            else $error("flags changed while updates are disabled");
        p_zero_flag_r5: assert (!flag_en_i || (z_o == (result_o == '0)))
            else $error("Z does not match the result");
        p_logic_clear_r6: assert (!flag_en_i || is_arith(op) || !v_o)
            else $error("V set by a non-arithmetic operation");
        p_right_carry_r7: assert (!(flag_en_i && op == OP_SHIFT && b_eff[SH_W-1])
                                  || !c_o)
            else $error("C set by a right shift");
    end

endmodule

// File: tb/alu_flags_core_test.sv
module alu_flags_core_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [2:0]  op;
    logic [31:0] a, b;
    logic [15:0] imm;
    logic        ui, hi, ar, en;
    logic [3:0]  fin;
    logic [31:0] res;
    logic        zo, no, vo, co;

    alu_flags_core uut (
        .op_i(op), .a_i(a), .b_reg_i(b), .imm_i(imm), .use_imm_i(ui),
        .imm_high_i(hi), .shift_arith_i(ar), .flag_en_i(en),
        .z_i(fin[3]), .n_i(fin[2]), .v_i(fin[1]), .c_i(fin[0]),
        .result_o(res), .z_o(zo), .n_o(no), .v_o(vo), .c_o(co)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct packed {
        logic [2:0]  op;
        logic        ui, hi, ar, cin;
        logic [31:0] a, b;
        logic [15:0] imm;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h7FFFFFFF, 32'h1,        16'h0,    32'h80000000}, // R1 R6
        '{3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'hFFFFFFFF, 32'h1,        16'h0,    32'h0},        // R7
        '{3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 32'h5,        32'h7,        16'h0,    32'hD},        // R4
        '{3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h80000000, 32'h1,        16'h0,    32'h7FFFFFFF}, // R6
        '{3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 32'hA,        32'h3,        16'h0,    32'h6},        // R4
        '{3'd4, 1'b1, 1'b0, 1'b0, 1'b0, 32'h12345678, 32'h0,        16'h00FF, 32'h12340078}, // R3
        '{3'd4, 1'b1, 1'b1, 1'b0, 1'b0, 32'h12345678, 32'h0,        16'h0F0F, 32'h02045678}, // R3
        '{3'd5, 1'b1, 1'b1, 1'b0, 1'b0, 32'h1,        32'h0,        16'hABCD, 32'hABCD0001}, // R2
        '{3'd6, 1'b1, 1'b0, 1'b0, 1'b0, 32'hFFFF0000, 32'h0,        16'h1234, 32'hFFFF1234}, // R2
        '{3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 32'hF0000001, 32'h0,        16'h0004, 32'h10},       // R9
        '{3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 32'h80000010, 32'h0,        16'hFFFC, 32'h08000001}, // R9
        '{3'd7, 1'b1, 1'b0, 1'b1, 1'b0, 32'h80000010, 32'h0,        16'hFFFC, 32'hF8000001}, // R9
        '{3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 32'h3,        32'd31,       16'h0,    32'h80000000}, // R9
        '{3'd7, 1'b0, 1'b0, 1'b1, 1'b0, 32'h80000000, 32'hFFFFFFE1, 16'h0,    32'hFFFFFFFF}, // R9
        '{3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h55,       32'h55,       16'h0,    32'h0},        // R5
        '{3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0,        32'h0,        16'h0001, 32'h00010000}  // R2
    };

    // Independent reference: signed/unsigned integer arithmetic, flags {Z,N,V,C}.
    function automatic void model(input logic [2:0] mop, input logic [31:0] ma, mb,
                                  input logic [15:0] mimm, input logic mui, mhi, mar, men,
                                  input logic [3:0] mfin,
                                  output logic [31:0] r, output logic [3:0] f);
        logic [31:0] bb, addend;
        logic [15:0] fill;
        logic        cin, v, c;
        longint      u, s;
        int          amt;
        logic [63:0] wide;
        if (mui) begin
            if (mop == 3'd7) bb = {{16{mimm[15]}}, mimm};
            else begin
                fill = (mop == 3'd4) ? 16'hFFFF : 16'h0000;
                bb = mhi ? {mimm, fill} : {fill, mimm};
            end
        end else bb = mb;
        v = 1'b0; c = 1'b0;
        if (mop[2] == 1'b0) begin
            addend = mop[1] ? ~bb : bb;
            cin = (mop == 3'd0) ? 1'b0 : (mop == 3'd2) ? 1'b1 : mfin[0];
            u = longint'(ma) + longint'(addend) + longint'(cin);
            s = longint'($signed(ma)) + longint'($signed(addend)) + longint'(cin);
            r = u[31:0];
            c = u[32];
            v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        end else if (mop == 3'd4) r = ma & bb;
        else if (mop == 3'd5) r = ma | bb;
        else if (mop == 3'd6) r = ma ^ bb;
        else begin
            amt = int'($signed(bb[5:0]));
            if (amt >= 0) begin
                wide = {32'h0, ma} << amt;
                r = wide[31:0];
                c = (amt == 0) ? 1'b0 : wide[32];
            end else begin
                r = mar ? 32'($signed(ma) >>> (-amt)) : (ma >> (-amt));
            end
        end
        f = men ? {(r == 32'h0), r[31], v, c} : mfin;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [2:0] p_op, input logic [31:0] p_a, p_b,
                         input logic [15:0] p_imm, input logic p_ui, p_hi, p_ar, p_en,
                         input logic [3:0] p_fin);
        @(posedge clk);
        op = p_op; a = p_a; b = p_b; imm = p_imm;
        ui = p_ui; hi = p_hi; ar = p_ar; en = p_en; fin = p_fin;
        @(negedge clk);
    endtask

    // Apply, then compare both result and flags with the model.
    task automatic run_model(input string req, input logic [2:0] p_op, input logic [31:0] p_a, p_b,
                             input logic p_en, input logic [3:0] p_fin);
        logic [31:0] er;
        logic [3:0]  ef;
        apply(p_op, p_a, p_b, 16'h0, 1'b0, 1'b0, p_op[0] & p_a[0], p_en, p_fin);
        model(p_op, p_a, p_b, 16'h0, 1'b0, 1'b0, p_op[0] & p_a[0], p_en, p_fin, er, ef);
        chk({req, " result"}, res, er);
        chk({req, " flags"}, {28'h0, zo, no, vo, co}, {28'h0, ef});
    endtask

    logic [31:0] corners [5] = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF};

    initial begin
        logic [31:0] er;
        logic [3:0]  ef;
        op = '0; a = '0; b = '0; imm = '0; ui = 0; hi = 0; ar = 0; en = 0; fin = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Reset-state check: zero inputs with update enabled give 0 and Z only (R5).
        apply(3'd0, 32'h0, 32'h0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0000);
        chk("R5 idle result", res, 32'h0);
        chk("R5 idle flags", {28'h0, zo, no, vo, co}, 32'h8);

        // Vector table: result from the table, flags from the model (R1..R9).
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i].op, VEC[i].a, VEC[i].b, VEC[i].imm, VEC[i].ui, VEC[i].hi,
                  VEC[i].ar, 1'b1, {3'b000, VEC[i].cin});
            model(VEC[i].op, VEC[i].a, VEC[i].b, VEC[i].imm, VEC[i].ui, VEC[i].hi,
                  VEC[i].ar, 1'b1, {3'b000, VEC[i].cin}, er, ef);
            chk("R1 table result", res, VEC[i].exp);
            chk("R6 R7 table flags", {28'h0, zo, no, vo, co}, {28'h0, ef});
        end

        // R8: flags pass through when the update is disabled.
        apply(3'd0, 32'hFFFFFFFF, 32'h1, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0101);
        chk("R8 hold flags", {28'h0, zo, no, vo, co}, 32'h5);
        chk("R1 add under hold", res, 32'h0);
        apply(3'd2, 32'h55, 32'h55, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b1010);
        chk("R8 hold flags sub", {28'h0, zo, no, vo, co}, 32'hA);

        // R4: carry-in chains through add with carry and subtract with borrow.
        apply(3'd1, 32'hFFFFFFFF, 32'h0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0001);
        chk("R4 addc result", res, 32'h0);
        chk("R4 addc flags", {28'h0, zo, no, vo, co}, 32'h9);
        apply(3'd3, 32'hA, 32'h3, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0001);
        chk("R4 subb with carry", res, 32'h7);

        // R7: a right shift clears C, and so does a zero-amount shift.
        apply(3'd7, 32'h1, 32'hFFFFFFFF, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0001);
        chk("R7 right shift result", res, 32'h0);
        chk("R7 right shift flags", {28'h0, zo, no, vo, co}, 32'h8);
        apply(3'd7, 32'h80000000, 32'h0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0001);
        chk("R7 zero shift result", res, 32'h80000000);
        chk("R7 zero shift flags", {28'h0, zo, no, vo, co}, 32'h4);

        // R10: with the register operand selected, the constant has no effect.
        apply(3'd0, 32'h1, 32'h2, 16'hFFFF, 1'b0, 1'b1, 1'b0, 1'b1, 4'b0000);
        chk("R10 register operand", res, 32'h3);

        // Sweep: every operation, boundary operands, both carry-in values (R1 R6 R7).
        for (int o = 0; o < 8; o++)
            for (int x = 0; x < 5; x++)
                for (int y = 0; y < 5; y++)
                    for (int k = 0; k < 2; k++)
                        run_model("R1 R6 R7 sweep", 3'(o), corners[x], corners[y],
                                  1'b1, {3'b000, 1'(k)});

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    int wd = 0;
    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 50000 && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule